// File: doc/BRIEF.md
# I2C Controller FIFO and Interrupt Unit

This block sits between the register interface of an I2C controller and its protocol engine. It holds two queues of 64 entries each. Software writes command words into the transmit queue, and the engine pops them. The engine pushes received bytes into the receive queue, and software pops them by reading a data register. Each queue has a clear control, a programmable fill threshold and two sticky error flags. One flag records a pop while the queue is empty. The other records a push while the queue is full.

Five interrupt sources feed one pending register: transfer done, transfer error, queue error, receive fill at or above its threshold, and transmit fill at or below its threshold. A mask register selects which pending bits reach the masked status register and the single interrupt line. Writing ones to the clear register removes pending bits. The three conditions that are levels set their bits again while the condition holds.

The register port uses 3-bit word addresses: 0 control, 1 transmit command (write only), 2 receive data (a read with `rd_en` pops one entry), 3 status, 4 interrupt mask, 5 masked interrupt status, 6 interrupt clear (write only). Read data follows `rd_addr` combinationally. A write takes effect at the clock edge that samples `wr_en`.

Top module: `i2c_fifo_irq`

## Requirements
- R1: After reset both queues are empty, all error flags are zero, the thresholds and the mask are zero, `irq` is low, `txq_valid` is low, and status reads 0x8.
- R2: Command words written to address 1 (low 11 bits) leave at `txq_cmd` in the order written, while `txq_valid` is high. Status bit 11 is set when 64 words are held.
- R3: Bytes pushed with `rxq_push` are returned by reads of address 2 with `rd_en`, in the order pushed. Status bit 3 is set when the receive queue is empty, and `rxq_full` is high when it holds 64 bytes.
- R4: A push into a full queue is dropped and sets that queue's write-error flag: status bit 1 for receive, bit 7 for transmit.
- R5: A pop from an empty queue returns zero and sets that queue's read-error flag: status bit 0 for receive, bit 6 for transmit.
- R6: Error flags stay set until their queue is cleared. A control write with bit 0 set empties the receive queue and zeroes its flags. Bit 1 does the same for the transmit queue. A clear wins over a push or pop in the same cycle.
- R7: Control bits 7:2 hold the receive threshold and bits 13:8 hold the transmit threshold. Both read back at the same positions, and the clear bits read as zero.
- R8: Pending bit 0 is set by a `xfer_done` pulse and bit 1 by a `xfer_err` pulse. Bit 2 is set while any of the four error flags is set. Bit 3 is set while the receive count is at or above its threshold. Bit 4 is set while the transmit count is at or below its threshold.
- R9: Address 5 reads pending AND mask. `irq` is the OR of those bits. Masking a bit hides it but does not discard it.
- R10: Writing ones to address 6 clears those pending bits. A bit whose set condition is true in the same cycle stays pending, so level sources persist while their condition holds.
- R11: A push and a pop in the same cycle act on the count before that edge. On a full queue the pop succeeds and the push is dropped with a write error. On an empty queue the push succeeds and the pop returns zero with a read error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Read strobe; pops the receive queue at address 2 |
| rd_addr | input | 3 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| txq_pop | input | 1 | Engine pops one transmit command |
| txq_valid | output | 1 | Transmit queue holds at least one command |
| txq_cmd | output | 11 | Head transmit command, zero when empty |
| rxq_push | input | 1 | Engine pushes one received byte |
| rxq_data | input | 8 | Received byte |
| rxq_full | output | 1 | Receive queue holds 64 bytes |
| xfer_done | input | 1 | Transfer complete event pulse |
| xfer_err | input | 1 | Transfer error event pulse |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to produce are the same-cycle collisions. One is a push and a pop at a full or empty boundary. Another is a clear arriving with a push. A third is an event pulse coinciding with its interrupt clear. The bench drives the software strobes and the engine strobes in the same clock cycle at those exact fill levels.

The bench separates level sources that re-pend from event sources that stay cleared. It clears each source while its condition still holds, then removes the condition and clears again. A seeded random mix of pushes and pops, first weighted toward filling and then toward draining, drives both queues through overflow and underflow while a reference model tracks their contents and flags.

// File: rtl/i2cfi_pkg.sv
package i2cfi_pkg;

  localparam int unsigned REG_AW = 3;
  localparam int unsigned NSRC   = 5;

  typedef enum logic [REG_AW-1:0] {
    RA_CTRL   = 3'd0,
    RA_TXCMD  = 3'd1,
    RA_RXDATA = 3'd2,
    RA_STATUS = 3'd3,
    RA_IMASK  = 3'd4,
    RA_IMSTAT = 3'd5,
    RA_ICLR   = 3'd6
  } reg_addr_e;

  // interrupt source positions (software decodes these)
  localparam int unsigned SRC_DONE  = 0;
  localparam int unsigned SRC_XERR  = 1;
  localparam int unsigned SRC_QERR  = 2;
  localparam int unsigned SRC_RXLVL = 3;
  localparam int unsigned SRC_TXLVL = 4;

  // status bit positions
  localparam int unsigned ST_RX_RERR = 0;
  localparam int unsigned ST_RX_WERR = 1;
  localparam int unsigned ST_RX_EMPT = 3;
  localparam int unsigned ST_TX_RERR = 6;
  localparam int unsigned ST_TX_WERR = 7;
  localparam int unsigned ST_TX_FULL = 11;

endpackage

// File: rtl/i2cfi_fifo.sv
module i2cfi_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             empty,
  output logic             full,
  output logic             rd_err,
  output logic             wr_err
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             rerr_q, rerr_d, werr_q, werr_d;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wp_d   = wp_q;
    rp_d   = rp_q;
    cnt_d  = cnt_q;
    rerr_d = rerr_q;
    werr_d = werr_q;
    if (clr) begin
      wp_d   = '0;
      rp_d   = '0;
      cnt_d  = '0;
      rerr_d = 1'b0;
      werr_d = 1'b0;
    end else begin
      if (do_push) wp_d = bump(wp_q);
      if (do_pop)  rp_d = bump(rp_q);
      cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
      if (pop && empty) rerr_d = 1'b1;
      if (push && full) werr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      rerr_q <= 1'b0;
      werr_q <= 1'b0;
    end else begin
      wp_q   <= wp_d;
      rp_q   <= rp_d;
      cnt_q  <= cnt_d;
      rerr_q <= rerr_d;
      werr_q <= werr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  assign head   = empty ? '0 : mem[rp_q];
  assign count  = cnt_q;
  assign rd_err = rerr_q;
  assign wr_err = werr_q;

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  a_r4_push_full_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !clr) |=> wr_err);
  a_r5_pop_empty_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !clr) |=> rd_err);
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && !rd_err && !wr_err));
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_err && !clr) |=> wr_err);
  a_r11_full_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && full && !clr) |=> (count == CW'(DEPTH-1)));

endmodule

// File: rtl/i2cfi_irq.sv
module i2cfi_irq #(
  parameter int unsigned NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_wdata,
  output logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] mstat,
  output logic            irq
);

  logic [NSRC-1:0] pend_q, pend_d, mask_q, mask_d, clr_v;

  always_comb begin
    clr_v  = clr_we ? clr_wdata : '0;
    pend_d = (pend_q & ~clr_v) | set;
    mask_d = mask_we ? mask_wdata : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
    end else begin
      pend_q <= pend_d;
      mask_q <= mask_d;
    end
  end

  assign mask  = mask_q;
  assign pend  = pend_q;
  assign mstat = pend_q & mask_q;
  assign irq   = |mstat;

  a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((pend & $past(clr_wdata & ~set)) == '0));
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((pend & $past(set)) == $past(set)));
  a_r9_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((pend & $past(pend)) == $past(pend)));

endmodule

// File: rtl/i2c_fifo_irq.sv
module i2c_fifo_irq
  import i2cfi_pkg::*;
#(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned CMD_W  = 11,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned REG_W  = 32,
  localparam int unsigned TW    = $clog2(DEPTH),
  localparam int unsigned CW    = TW + 1,
  localparam int unsigned RXT_LSB = 2,
  localparam int unsigned TXT_LSB = RXT_LSB + TW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              txq_pop,
  output logic              txq_valid,
  output logic [CMD_W-1:0]  txq_cmd,
  input  logic              rxq_push,
  input  logic [DATA_W-1:0] rxq_data,
  output logic              rxq_full,
  input  logic              xfer_done,
  input  logic              xfer_err,
  output logic              irq
);

  logic [TW-1:0]     thr_rx_q, thr_rx_d, thr_tx_q, thr_tx_d;
  logic              ctrl_we, rx_clr, tx_clr, tx_push, rx_pop;
  logic [CW-1:0]     rx_cnt, tx_cnt;
  logic              rx_empty, rx_full_i, tx_empty, tx_full;
  logic              rx_rerr, rx_werr, tx_rerr, tx_werr;
  logic [DATA_W-1:0] rx_head;
  logic [NSRC-1:0]   src_set, mask, pend, mstat;
  logic [REG_W-1:0]  status;
  logic              unused_wr_bits;

  assign ctrl_we = wr_en && (wr_addr == RA_CTRL);
  assign rx_clr  = ctrl_we && wr_data[0];
  assign tx_clr  = ctrl_we && wr_data[1];
  assign tx_push = wr_en && (wr_addr == RA_TXCMD);
  assign rx_pop  = rd_en && (rd_addr == RA_RXDATA);
  assign unused_wr_bits = ^wr_data;

  always_comb begin
    thr_rx_d = thr_rx_q;
    thr_tx_d = thr_tx_q;
    if (ctrl_we) begin
      thr_rx_d = wr_data[RXT_LSB +: TW];
      thr_tx_d = wr_data[TXT_LSB +: TW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_rx_q <= '0;
      thr_tx_q <= '0;
    end else begin
      thr_rx_q <= thr_rx_d;
      thr_tx_q <= thr_tx_d;
    end
  end

  i2cfi_fifo #(.DEPTH(DEPTH), .WIDTH(CMD_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(tx_push), .push_data(wr_data[CMD_W-1:0]),
    .pop(txq_pop), .head(txq_cmd), .count(tx_cnt),
    .empty(tx_empty), .full(tx_full), .rd_err(tx_rerr), .wr_err(tx_werr)
  );

  i2cfi_fifo #(.DEPTH(DEPTH), .WIDTH(DATA_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(rxq_push), .push_data(rxq_data),
    .pop(rx_pop), .head(rx_head), .count(rx_cnt),
    .empty(rx_empty), .full(rx_full_i), .rd_err(rx_rerr), .wr_err(rx_werr)
  );

  assign txq_valid = !tx_empty;
  assign rxq_full  = rx_full_i;

  always_comb begin
    src_set            = '0;
    src_set[SRC_DONE]  = xfer_done;
    src_set[SRC_XERR]  = xfer_err;
    src_set[SRC_QERR]  = rx_rerr | rx_werr | tx_rerr | tx_werr;
    src_set[SRC_RXLVL] = (rx_cnt >= {1'b0, thr_rx_q});
    src_set[SRC_TXLVL] = (tx_cnt <= {1'b0, thr_tx_q});
  end

  i2cfi_irq #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(src_set),
    .mask_we(wr_en && (wr_addr == RA_IMASK)), .mask_wdata(wr_data[NSRC-1:0]),
    .clr_we(wr_en && (wr_addr == RA_ICLR)), .clr_wdata(wr_data[NSRC-1:0]),
    .mask(mask), .pend(pend), .mstat(mstat), .irq(irq)
  );

  always_comb begin
    status             = '0;
    status[ST_RX_RERR] = rx_rerr;
    status[ST_RX_WERR] = rx_werr;
    status[ST_RX_EMPT] = rx_empty;
    status[ST_TX_RERR] = tx_rerr;
    status[ST_TX_WERR] = tx_werr;
    status[ST_TX_FULL] = tx_full;
  end

  always_comb begin
    rd_data = '0;
    case (reg_addr_e'(rd_addr))
      RA_CTRL: begin
        rd_data[RXT_LSB +: TW] = thr_rx_q;
        rd_data[TXT_LSB +: TW] = thr_tx_q;
      end
      RA_RXDATA: rd_data[DATA_W-1:0] = rx_head;
      RA_STATUS: rd_data = status;
      RA_IMASK:  rd_data[NSRC-1:0] = mask;
      RA_IMSTAT: rd_data[NSRC-1:0] = mstat;
      default:   rd_data = '0;
    endcase
  end

  a_r8_qerr_source: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rerr || rx_werr || tx_rerr || tx_werr) |=> pend[SRC_QERR]);
  a_r8_done_source: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> pend[SRC_DONE]);
  a_r3_rx_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_clr || rx_pop) |=> !rxq_full);

endmodule

// File: tb/tb_i2c_fifo_irq.sv
`timescale 1ns/1ps
module tb_i2c_fifo_irq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en, txq_pop, rxq_push, xfer_done, xfer_err;
  logic [2:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        txq_valid, rxq_full, irq;
  logic [10:0] txq_cmd;
  logic [7:0]  rxq_data;

  int total = 0;
  int bad   = 0;
  bit done_flag = 0;

  logic [10:0] txm[$];
  logic [7:0]  rxm[$];
  bit m_rx_rerr, m_rx_werr, m_tx_rerr, m_tx_werr;

  always #2 clk = ~clk;

  i2c_fifo_irq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .txq_pop(txq_pop), .txq_valid(txq_valid), .txq_cmd(txq_cmd),
    .rxq_push(rxq_push), .rxq_data(rxq_data), .rxq_full(rxq_full),
    .xfer_done(xfer_done), .xfer_err(xfer_err), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    s[0]  = m_rx_rerr;
    s[1]  = m_rx_werr;
    s[3]  = (rxm.size() == 0);
    s[6]  = m_tx_rerr;
    s[7]  = m_tx_werr;
    s[11] = (txm.size() == 64);
    return s;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input bit pop, output logic [31:0] d);
    rd_addr = a;
    #1 d = rd_data;
    rd_en = pop;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic eng_pop(output logic v, output logic [10:0] c);
    #1 v = txq_valid; c = txq_cmd;
    txq_pop = 1'b1;
    @(negedge clk);
    txq_pop = 1'b0;
  endtask

  task automatic eng_push(input logic [7:0] b);
    rxq_push = 1'b1; rxq_data = b;
    @(negedge clk);
    rxq_push = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_clear();
    txm.delete(); rxm.delete();
    m_rx_rerr = 0; m_rx_werr = 0; m_tx_rerr = 0; m_tx_werr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        v;
    logic [10:0] c;
    rst_n = 1'b0; wr_en = 0; rd_en = 0; txq_pop = 0; rxq_push = 0;
    xfer_done = 0; xfer_err = 0; wr_addr = 0; rd_addr = 0; wr_data = 0; rxq_data = 0;
    model_clear();
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd3, 0, d); check("R1 status", d, 32'h8);
    rd(3'd0, 0, d); check("R1 ctrl", d, 32'h0);
    rd(3'd4, 0, d); check("R1 mask", d, 32'h0);
    rd(3'd5, 0, d); check("R1 imstat", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 txq_valid", {31'b0, txq_valid}, 32'h0);

    // R2 R3 R4 R5 random traffic with reference model
    for (int i = 0; i < 1200; i++) begin
      int op, w;
      w  = (i < 600) ? 75 : 25;
      op = (($urandom % 100) < w) ? 0 : 1;
      op = op * 2 + ($urandom % 2);
      case (op)
        0: begin
          c = 11'($urandom);
          wr(3'd1, {21'b0, c});
          if (txm.size() < 64) txm.push_back(c); else m_tx_werr = 1;
        end
        1: begin
          d = 32'($urandom % 256);
          eng_push(d[7:0]);
          if (rxm.size() < 64) rxm.push_back(d[7:0]); else m_rx_werr = 1;
        end
        2: begin
          eng_pop(v, c);
          if (txm.size() > 0) begin
            check("R2 tx order", {20'b0, v, c}, {20'b0, 1'b1, txm.pop_front()});
          end else begin
            check("R5 tx empty pop", {20'b0, v, c}, 32'h0);
            m_tx_rerr = 1;
          end
        end
        default: begin
          rd(3'd2, 1, d);
          if (rxm.size() > 0) check("R3 rx order", d, {24'b0, rxm.pop_front()});
          else begin
            check("R5 rx empty pop", d, 32'h0);
            m_rx_rerr = 1;
          end
        end
      endcase
      rd(3'd3, 0, d); check("R4 R6 status", d, exp_status());
      check("R3 rxq_full", {31'b0, rxq_full}, {31'b0, rxm.size() == 64});
      check("R9 irq masked", {31'b0, irq}, 32'h0);
    end

    // R6 clear both queues and flags
    wr(3'd0, 32'h3); model_clear();
    rd(3'd3, 0, d); check("R6 clear status", d, 32'h8);
    check("R6 clear txq_valid", {31'b0, txq_valid}, 32'h0);

    // R4 R5 directed rx overflow and underflow
    for (int i = 0; i < 65; i++) eng_push(8'(i + 1));
    rd(3'd3, 0, d); check("R4 rx overflow", d, 32'h2);
    for (int i = 0; i < 64; i++) begin
      rd(3'd2, 1, d); check("R3 rx fill order", d, 32'(i + 1));
    end
    rd(3'd2, 1, d); check("R5 rx underflow data", d, 32'h0);
    rd(3'd3, 0, d); check("R6 rx flags sticky", d, 32'hB);

    // R7 thresholds, clear both queues
    wr(3'd0, 32'h213);
    rd(3'd0, 0, d); check("R7 ctrl readback", d, 32'h210);
    rd(3'd3, 0, d); check("R6 flags cleared", d, 32'h8);
    wr(3'd6, 32'h1F); idle(2);
    wr(3'd4, 32'h1F);
    rd(3'd5, 0, d); check("R8 tx level at zero", d, 32'h10);
    check("R9 irq high", {31'b0, irq}, 32'h1);
    for (int i = 0; i < 3; i++) wr(3'd1, 32'(i + 16));
    wr(3'd6, 32'h10); idle(2);
    rd(3'd5, 0, d); check("R10 tx level gone", d, 32'h0);
    check("R9 irq low", {31'b0, irq}, 32'h0);
    for (int i = 0; i < 4; i++) eng_push(8'(i + 100));
    idle(2);
    rd(3'd5, 0, d); check("R8 rx level reached", d, 32'h08);
    wr(3'd6, 32'h08); idle(2);
    rd(3'd5, 0, d); check("R10 level re-pends", d, 32'h08);
    rd(3'd2, 1, d); check("R3 rx data", d, 32'd100);
    wr(3'd6, 32'h08); idle(2);
    rd(3'd5, 0, d); check("R10 rx level cleared", d, 32'h0);

    // R8 R9 events and masking
    xfer_done = 1; @(negedge clk); xfer_done = 0;
    xfer_err = 1; @(negedge clk); xfer_err = 0;
    idle(1);
    wr(3'd4, 32'h1C);
    rd(3'd5, 0, d); check("R9 masked events hidden", d, 32'h0);
    check("R9 irq masked off", {31'b0, irq}, 32'h0);
    wr(3'd4, 32'h1F);
    rd(3'd5, 0, d); check("R8 events pending", d, 32'h03);
    wr(3'd6, 32'h01); idle(1);
    rd(3'd5, 0, d); check("R10 clear one event", d, 32'h02);
    xfer_err = 1; wr(3'd6, 32'h02); xfer_err = 0; idle(1);
    rd(3'd5, 0, d); check("R10 event beats clear", d, 32'h02);
    wr(3'd6, 32'h02); idle(1);
    rd(3'd5, 0, d); check("R10 event cleared", d, 32'h0);

    // R8 queue error source: tx holds 3
    for (int i = 0; i < 3; i++) begin
      eng_pop(v, c); check("R2 tx head", {20'b0, v, c}, {20'b0, 1'b1, 11'(i + 16)});
    end
    eng_pop(v, c); check("R5 tx underflow", {20'b0, v, c}, 32'h0);
    idle(2);
    rd(3'd5, 0, d); check("R8 qerr and tx level", d, 32'h14);
    wr(3'd6, 32'h14); idle(2);
    rd(3'd5, 0, d); check("R10 sticky flag re-pends", d, 32'h14);
    wr(3'd0, 32'h212); idle(1);
    wr(3'd6, 32'h04); idle(2);
    rd(3'd5, 0, d); check("R6 R8 qerr gone after clear", d, 32'h10);

    // R11 full transmit queue: push and pop together
    wr(3'd0, 32'h213);
    for (int i = 0; i < 64; i++) wr(3'd1, 32'(i));
    rd(3'd3, 0, d); check("R2 tx full", d, 32'h808);
    wr_en = 1; wr_addr = 3'd1; wr_data = 32'h7AA;
    #1 c = txq_cmd; txq_pop = 1;
    @(negedge clk); wr_en = 0; txq_pop = 0;
    check("R11 popped head", {21'b0, c}, 32'h0);
    rd(3'd3, 0, d); check("R11 full push dropped", d, 32'h88);
    #1 check("R11 next head", {21'b0, txq_cmd}, 32'h1);

    // R11 empty receive queue: push and pop together
    wr(3'd0, 32'h213);
    rd_addr = 3'd2; rxq_push = 1; rxq_data = 8'h5A;
    #1 d = rd_data; rd_en = 1;
    @(negedge clk); rd_en = 0; rxq_push = 0;
    check("R11 empty pop zero", d, 32'h0);
    rd(3'd3, 0, d); check("R11 push kept, rerr", d, 32'h1);
    rd(3'd2, 1, d); check("R11 pushed byte", d, 32'h5A);

    // R6 clear beats a push in the same cycle
    rxq_push = 1; rxq_data = 8'h33;
    wr(3'd0, 32'h211);
    rxq_push = 0;
    rd(3'd3, 0, d); check("R6 clear wins push", d, 32'h8);

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule